// File: doc/BRIEF.md
# Conversion Cycle Sequencer

This block steps a sampling converter through its power-on, conversion and sleep phases. After reset it waits out a power-on interval in which every register is cleared. It then runs one conversion in the fast rate mode on its own. When the conversion timer runs out, the block goes to sleep and keeps the last result in a static hold register for as long as nobody asks for a new one. The conversion timer lasts a parameterised number of system-clock cycles. The slow rate mode takes exactly twice as long as the fast mode.

The block gets its requests as single-cycle event pulses from the bus slave. One pulse means a Stop followed a valid read or write, and the other means all result bits have been shifted out. Either pulse starts a new conversion, but only while the block sleeps. A rate byte from a write goes into a pending register and takes effect when the next conversion starts. The modulator and filter appear only as a wide signed result with a done strobe. The result is clamped into the unsigned code range when it is captured. Busy is high for the whole power-on and conversion time, and the bus slave uses it to refuse address requests. A sleep output stands in for power gating.

Top module: `conv_seq`

## Requirements
- R1: After `rst_n` is released, the block stays busy for POR_CYCLES cycles of power-on. A conversion then starts by itself, and `sleep_o` rises exactly POR_CYCLES + FAST_CYCLES rising edges after the release.
- R2: While `rst_n` is low, including in the middle of a conversion, the block shows `busy_o`=1, `sleep_o`=0, `result_o`=0 and `slow_mode_o`=0. The first conversion after reset always runs in the fast mode.
- R3: When a conversion ends, `sleep_o`=1 and `busy_o`=0. The block then keeps `result_o` and stays asleep, with no limit on time, until a start event arrives.
- R4: While the block sleeps, a one-cycle pulse on either `ev_stop_i` or `ev_rd_done_i` starts a conversion. `busy_o` rises one cycle after the pulse.
- R5: A conversion lasts FAST_CYCLES cycles when `slow_mode_o`=0 and 2*FAST_CYCLES cycles when `slow_mode_o`=1.
- R6: A pulse on `cfg_wr_i` records `cfg_slow_i` as the rate for later conversions (1 = slow, 0 = fast). `slow_mode_o` takes the recorded rate only when the next conversion starts. It does not change during a conversion that is already running.
- R7: `mod_result_i` is a signed value RES_W+2 bits wide. When it is captured, a negative value becomes 0, a value above 2^RES_W-1 becomes 2^RES_W-1, and any other value passes through unchanged.
- R8: Start events that arrive during power-on or during a conversion are ignored. They neither restart the conversion nor make it longer.
- R9: A `mod_done_i` strobe during a conversion captures the result at once, but busy stays high until the timer ends. A strobe outside a conversion leaves `result_o` unchanged.
- R10: `conv_start_o` goes high for one cycle at the start of each conversion, whether the conversion follows power-on or a start event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; its release begins the power-on interval |
| ev_stop_i | input | 1 | Pulse: Stop after a valid read or write |
| ev_rd_done_i | input | 1 | Pulse: all result bits have been read out |
| cfg_wr_i | input | 1 | Pulse: rate byte received |
| cfg_slow_i | input | 1 | Rate bit of that byte (1 = slow mode) |
| mod_done_i | input | 1 | Strobe from the modulator: result valid |
| mod_result_i | input | RES_W+2 | Signed, unclamped modulator result |
| busy_o | output | 1 | High during power-on and conversion |
| sleep_o | output | 1 | High while the block sleeps and holds its result |
| conv_start_o | output | 1 | One-cycle pulse when a conversion starts |
| slow_mode_o | output | 1 | Rate mode of the current or last conversion |
| result_o | output | RES_W | Clamped result held for the bus |

## Verification
The assertions assume that the start and write events are single-cycle pulses from a slave that is synchronous to `clk`. They also assume that POR_CYCLES fits inside the counter sized for the slow conversion. The bench keeps every event to exactly one cycle. It raises a stray Stop pulse inside every conversion and sends done strobes only at fixed cycle offsets. It uses a small configuration (8 power-on cycles, 12 fast cycles) so that conversion lengths and clamp boundaries can be swept completely.

// File: rtl/conv_pkg.sv
package conv_pkg;
    typedef enum logic [1:0] {
        ST_POR   = 2'd0,
        ST_CONV  = 2'd1,
        ST_SLEEP = 2'd2
    } seq_state_e;
endpackage

// File: rtl/conv_timer.sv
module conv_timer #(
    parameter int              CNT_W     = 8,
    parameter logic [CNT_W-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= RESET_VAL;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/conv_clamp.sv
module conv_clamp #(
    parameter int RES_W = 16,
    parameter int RAW_W = RES_W + 2
) (
    input  logic [RAW_W-1:0] raw,
    output logic [RES_W-1:0] code
);
    logic negative, overflow;

    always_comb begin
        negative = raw[RAW_W-1];
        overflow = |raw[RAW_W-2:RES_W];
        if (negative)
            code = '0;
        else if (overflow)
            code = '1;
        else
            code = raw[RES_W-1:0];
    end
endmodule

// File: rtl/conv_seq.sv
module conv_seq
    import conv_pkg::*;
#(
    parameter int RES_W       = 16,
    parameter int POR_CYCLES  = 50000,
    parameter int FAST_CYCLES = 1660000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_stop_i,
    input  logic             ev_rd_done_i,
    input  logic             cfg_wr_i,
    input  logic             cfg_slow_i,
    input  logic             mod_done_i,
    input  logic [RES_W+1:0] mod_result_i,
    output logic             busy_o,
    output logic             sleep_o,
    output logic             conv_start_o,
    output logic             slow_mode_o,
    output logic [RES_W-1:0] result_o
);
    localparam int RAW_W = RES_W + 2;
    localparam int CNT_W = $clog2(2 * FAST_CYCLES + 1);
    localparam logic [CNT_W-1:0] POR_LEN  = CNT_W'(POR_CYCLES - 1);
    localparam logic [CNT_W-1:0] FAST_LEN = CNT_W'(FAST_CYCLES - 1);
    localparam logic [CNT_W-1:0] SLOW_LEN = CNT_W'(2 * FAST_CYCLES - 1);

    typedef struct packed {
        seq_state_e       st;
        logic             slow;
        logic             pend;
        logic             kick;
        logic [RES_W-1:0] res;
    } seq_regs_t;

    seq_regs_t        r_d, r_q;
    logic             tmr_load, tmr_zero;
    logic [CNT_W-1:0] tmr_val;
    logic [RES_W-1:0] clamped;
    logic             start_ev;

    conv_clamp #(.RES_W(RES_W), .RAW_W(RAW_W)) u_clamp (
        .raw  (mod_result_i),
        .code (clamped)
    );

    conv_timer #(.CNT_W(CNT_W), .RESET_VAL(POR_LEN)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    assign start_ev = ev_stop_i | ev_rd_done_i;

    always_comb begin
        r_d      = r_q;
        r_d.kick = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = FAST_LEN;
        if (cfg_wr_i) r_d.pend = cfg_slow_i;
        case (r_q.st)
            ST_POR: begin
                if (tmr_zero) begin
                    r_d.st   = ST_CONV;
                    r_d.slow = 1'b0;
                    r_d.kick = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = FAST_LEN;
                end
            end
            ST_CONV: begin
                if (mod_done_i) r_d.res = clamped;
                if (tmr_zero)   r_d.st  = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (start_ev) begin
                    r_d.st   = ST_CONV;
                    r_d.slow = r_q.pend;
                    r_d.kick = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = r_q.pend ? SLOW_LEN : FAST_LEN;
                end
            end
            default: r_d.st = ST_POR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_POR;
            r_q.slow <= 1'b0;
            r_q.pend <= 1'b0;
            r_q.kick <= 1'b0;
            r_q.res  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o       = (r_q.st != ST_SLEEP);
    assign sleep_o      = (r_q.st == ST_SLEEP);
    assign conv_start_o = r_q.kick;
    assign slow_mode_o  = r_q.slow;
    assign result_o     = r_q.res;

    AST_CONV_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CONV && !tmr_zero) |=> (r_q.st == ST_CONV)); // R8

    AST_END_TO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CONV && tmr_zero) |=> sleep_o); // R5

    AST_HOLD_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o |=> $stable(result_o)); // R3

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_o |=> $stable(slow_mode_o)); // R6

    AST_KICK_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> (busy_o && r_q.st == ST_CONV)); // R10
endmodule

// File: tb/tb_conv_seq.sv
`timescale 1ns/1ps
module tb_conv_seq;
    localparam int RES_W = 16;
    localparam int POR_C = 8;
    localparam int FAST_C = 12;
    localparam int MAXC = (1 << RES_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_stop = 1'b0, ev_rd = 1'b0, cfg_wr = 1'b0, cfg_slow = 1'b0, mod_done = 1'b0;
    logic [RES_W+1:0] mod_res = '0;
    logic busy, sleep, kick, slow;
    logic [RES_W-1:0] result;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    conv_seq #(.RES_W(RES_W), .POR_CYCLES(POR_C), .FAST_CYCLES(FAST_C)) dut (
        .clk(clk), .rst_n(rst_n), .ev_stop_i(ev_stop), .ev_rd_done_i(ev_rd),
        .cfg_wr_i(cfg_wr), .cfg_slow_i(cfg_slow), .mod_done_i(mod_done),
        .mod_result_i(mod_res), .busy_o(busy), .sleep_o(sleep),
        .conv_start_o(kick), .slow_mode_o(slow), .result_o(result)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clamp_exp(input int v);
        if (v < 0) return 0;
        if (v > MAXC) return MAXC;
        return v;
    endfunction

    // Counts rising edges until sleep is seen; returns count.
    task automatic wait_sleep(output int n, input int limit);
        n = 0;
        while (n < limit) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (sleep) break;
        end
    endtask

    task automatic run_conv(input int exp_len, input bit via_read, input int raw_v,
                            input int done_at, input int wr_at, input bit wr_val);
        int n;
        n = 0;
        @(negedge clk);
        if (via_read) ev_rd = 1'b1; else ev_stop = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ev_rd = 1'b0; ev_stop = 1'b0;
        chk(kick == 1'b1, "R10 start pulse", kick, 1);
        chk(busy == 1'b1, "R4 start event", busy, 1);
        while (n < 3 * exp_len + 10) begin
            if (n == done_at) begin mod_done = 1'b1; mod_res = (RES_W+2)'(raw_v); end
            if (n == 4) ev_stop = 1'b1;                 // R8 stray start
            if (n == wr_at) begin cfg_wr = 1'b1; cfg_slow = wr_val; end
            @(posedge clk); n++;
            @(negedge clk);
            mod_done = 1'b0; ev_stop = 1'b0; cfg_wr = 1'b0;
            if (n == 1) chk(kick == 1'b0, "R10 single cycle", kick, 0);
            if (sleep) break;
        end
        chk(n == exp_len, "R5/R8/R9 conversion length", n, exp_len);
        chk(busy == 1'b0, "R3 busy low in sleep", busy, 0);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        int held;
        int vals[9] = '{-131072, -1, 0, 1, 32768, 65534, 65535, 65536, 131071};

        repeat (3) @(negedge clk);
        chk(busy == 1'b1, "R2 busy in reset", busy, 1);
        chk(sleep == 1'b0, "R2 sleep in reset", sleep, 0);
        chk(result == 0, "R2 result in reset", result, 0);
        chk(slow == 1'b0, "R2 mode in reset", slow, 0);

        rst_n = 1'b1;
        ev_stop = 1'b1;                                  // R8 ignored during power-on
        @(negedge clk); ev_stop = 1'b0;
        n = 1;
        begin
            int m;
            wait_sleep(m, 200);
            n = n + m;
        end
        chk(n == POR_C + FAST_C, "R1 power-on plus first conversion", n, POR_C + FAST_C);
        chk(slow == 1'b0, "R1 first conversion fast", slow, 0);
        chk(sleep == 1'b1, "R3 sleep after conversion", sleep, 1);
        chk(result == 0, "R9 no strobe keeps result", result, 0);

        foreach (vals[i]) begin                          // R7 clamp sweep
            run_conv(FAST_C, 1'b0, vals[i], 2, -1, 1'b0);
            chk(int'(result) == clamp_exp(vals[i]), "R7 clamp", result, clamp_exp(vals[i]));
        end

        held = int'(result);                             // R3 / R9 hold in sleep
        for (int k = 0; k < 40; k++) begin
            mod_done = (k < 5); mod_res = (RES_W+2)'(1234);
            @(negedge clk);
        end
        mod_done = 1'b0;
        chk(sleep == 1'b1, "R3 no spontaneous start", sleep, 1);
        chk(int'(result) == held, "R9 strobe in sleep ignored", result, held);

        run_conv(FAST_C, 1'b1, 777, FAST_C - 1, -1, 1'b0);   // R4 read-done start, late strobe
        chk(result == 777, "R4 read-done conversion result", result, 777);

        @(negedge clk); cfg_wr = 1'b1; cfg_slow = 1'b1;
        @(negedge clk); cfg_wr = 1'b0;
        chk(slow == 1'b0, "R6 mode not applied in sleep", slow, 0);
        run_conv(2 * FAST_C, 1'b0, 4321, 0, 3, 1'b0);   // slow, with fast written mid-run
        chk(slow == 1'b1, "R6 slow active", slow, 1);
        chk(result == 4321, "R9 early strobe captured", result, 4321);
        run_conv(FAST_C, 1'b0, 99, 5, -1, 1'b0);
        chk(slow == 1'b0, "R6 fast applied at next start", slow, 0);

        @(negedge clk); cfg_wr = 1'b1; cfg_slow = 1'b1;  // R2 reset mid-conversion
        @(negedge clk); cfg_wr = 1'b0; ev_stop = 1'b1;
        @(negedge clk); ev_stop = 1'b0;
        repeat (3) @(negedge clk);
        chk(slow == 1'b1, "R6 slow running before reset", slow, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(result == 0, "R2 reset clears result", result, 0);
        chk(slow == 1'b0, "R2 reset clears mode", slow, 0);
        chk(busy == 1'b1, "R2 busy after reset", busy, 1);
        rst_n = 1'b1;
        wait_sleep(n, 200);
        chk(n == POR_C + FAST_C, "R2 fast conversion after reset", n, POR_C + FAST_C);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule